// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Register Test Port

This block holds 32 address translations arranged as four ways of eight sets. Each entry maps a 20-bit linear page number to a 20-bit physical page number. Each entry also carries a valid bit and three attribute bits: dirty, user/supervisor and read/write. Page-table walking and normal-operation replacement are outside this block. The only way into the array is a pair of register-style test interfaces: a command register and a data register.

Writing the command register starts an operation at once. Command bit 0 selects the operation: 0 stores an entry and 1 performs a lookup. The operation takes one busy cycle, after which the result is left in the two registers for readback.

Each attribute travels as a true/complement bit pair. The valid bit is compared like an address bit. On a write, the target way comes from a field of the data register. A `flush` input clears every valid bit. A `permit` input stands in for privilege checking: when it is low, any register access is refused and raises a one-cycle fault pulse.

The control is a three-state machine:
- `ST_IDLE` is the resting state.
- `ST_IDLE -> ST_WRITE` is taken on an accepted command with bit 0 = 0.
- `ST_IDLE -> ST_LOOKUP` is taken on an accepted command with bit 0 = 1.
- `ST_WRITE -> ST_IDLE` and `ST_LOOKUP -> ST_IDLE` are taken unconditionally after one cycle, and this is when the result is committed.

Top module: `tlb_test_port`

## Requirements
- R1: After reset both registers read 0, `busy`, `fault` and `multi_err` are low, and every entry is invalid with all fields 0.
- R2: The command register layout is: [31:12] page, [7] valid, [6:5] dirty pair (true, complement), [4:3] user pair, [2:1] read/write pair, [0] operation. The data register layout is: [31:12] physical page, [4] hit flag, [3:2] way. A write (operation 0) with data hit flag 1 stores page, valid, the true bit of each pair, and the physical page into set page[2:0] of the selected way.
- R3: A write whose data-register hit flag is 0 leaves the array unchanged. The command register still takes the written value.
- R4: A lookup that matches exactly one entry sets data = {physical page, hit=1, way}. The command register keeps the page and valid bit, and each attribute pair is rewritten as (stored, not stored).
- R5: On lookup, pair 10 matches only a stored 1, pair 01 matches only a stored 0, pair 11 matches either, and pair 00 matches nothing.
- R6: The lookup valid bit must equal the stored valid bit for a match, so a lookup with valid 0 can hit an invalid entry whose tag matches.
- R7: On a miss, the data register becomes 0 and the command register holds the written command unchanged.
- R8: When more than one entry matches, the lookup reports a miss as in R7, and `multi_err` is high for the single cycle in which the results appear.
- R9: A `flush` cycle clears every valid bit and keeps all other entry fields.
- R10: `busy` is high for exactly the one cycle after an accepted command. Reads during that cycle return the values from before the command. Register writes during that cycle are ignored.
- R11: With `permit` low, any access (`cmd_wr`, `dat_wr` or `rd_en`) is ignored and reads return 0. `fault` is high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| permit | input | 1 | Access allowed when high |
| flush | input | 1 | Clear all valid bits |
| cmd_wr | input | 1 | Write command register and start operation |
| cmd_wdata | input | 32 | Command register write value |
| dat_wr | input | 1 | Write data register |
| dat_wdata | input | 32 | Data register write value |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects command register, 1 selects data register |
| rd_data | output | 32 | Read value, 0 when not reading or not permitted |
| busy | output | 1 | Operation in progress |
| fault | output | 1 | One-cycle pulse after a refused access |
| multi_err | output | 1 | One-cycle pulse on a lookup with several matches |

## Verification
The assertions watch the following properties on every cycle:
- `busy` lasts a single cycle and starts only after a permitted command write.
- `fault` pulses exactly after a refused access.
- A refused write while idle changes neither the data register nor the state.
- `multi_err` never coincides with a reported hit.

Some behaviours depend on what the array holds, and only the bench's scenarios can show them. These include attribute pair matching, the valid bit acting as an address bit, the way-selected placement, ignored writes with a cleared hit flag, flush retaining tags, and duplicate-tag detection. The bench checks them against a reference model of the array.

// File: rtl/tlb_tp_pkg.sv
`timescale 1ns/1ps
package tlb_tp_pkg;
    localparam int REG_W   = 32;
    // command register fields
    localparam int OP_BIT  = 0;
    localparam int RW_T    = 2;
    localparam int RW_C    = 1;
    localparam int US_T    = 4;
    localparam int US_C    = 3;
    localparam int DT_T    = 6;
    localparam int DT_C    = 5;
    localparam int VLD_BIT = 7;
    localparam int PG_LSB  = 12;
    // data register fields
    localparam int HIT_BIT = 4;
    localparam int WAY_LSB = 2;
    // attribute vector positions
    localparam int A_D     = 2;
    localparam int A_U     = 1;
    localparam int A_W     = 0;
    localparam int ATTR_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_LOOKUP = 2'd2
    } tp_state_e;

    // stored bit accepted by a (true, complement) request pair
    function automatic logic pair_ok(input logic stored, input logic t, input logic c);
        return (stored & t) | (~stored & c);
    endfunction
endpackage

// File: rtl/tlb_tp_ctrl.sv
`timescale 1ns/1ps
module tlb_tp_ctrl
    import tlb_tp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_lookup,
    output logic busy,
    output logic do_write,
    output logic do_lookup
);
    tp_state_e state_q;
    tp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = start_lookup ? ST_LOOKUP : ST_WRITE;
            ST_WRITE:  state_d = ST_IDLE;
            ST_LOOKUP: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        do_write  = 1'b0;
        do_lookup = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WRITE:  begin busy = 1'b1; do_write  = 1'b1; end
            ST_LOOKUP: begin busy = 1'b1; do_lookup = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/tlb_tp_array.sv
`timescale 1ns/1ps
module tlb_tp_array
    import tlb_tp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         we,
    input  logic [WAY_W-1:0]             we_way,
    input  logic [IDX_W-1:0]             we_idx,
    input  logic [VPN_W-1:0]             we_vpn,
    input  logic                         we_vld,
    input  logic [ATTR_W-1:0]            we_attr,
    input  logic [PPN_W-1:0]             we_ppn,
    input  logic [IDX_W-1:0]             lk_idx,
    input  logic [VPN_W-1:0]             lk_vpn,
    input  logic                         lk_vld,
    input  logic [ATTR_W-1:0]            lk_t,
    input  logic [ATTR_W-1:0]            lk_c,
    output logic [WAYS-1:0]              match,
    output logic [WAYS-1:0][PPN_W-1:0]   way_ppn,
    output logic [WAYS-1:0][ATTR_W-1:0]  way_attr
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [VPN_W-1:0]  vpn_q  [SETS];
        logic [ATTR_W-1:0] attr_q [SETS];
        logic [PPN_W-1:0]  ppn_q  [SETS];
        logic              sel_w;
        logic              attr_hit;

        assign sel_w = we && (we_way == WAY_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
                for (int s = 0; s < SETS; s++) begin
                    vpn_q[s]  <= '0;
                    attr_q[s] <= '0;
                    ppn_q[s]  <= '0;
                end
            end else begin
                if (sel_w) begin
                    vpn_q[we_idx]  <= we_vpn;
                    attr_q[we_idx] <= we_attr;
                    ppn_q[we_idx]  <= we_ppn;
                end
                if (flush)      vld_q         <= '0;
                else if (sel_w) vld_q[we_idx] <= we_vld;
            end
        end

        always_comb begin
            attr_hit = 1'b1;
            for (int a = 0; a < ATTR_W; a++)
                attr_hit = attr_hit & pair_ok(attr_q[lk_idx][a], lk_t[a], lk_c[a]);
        end

        assign match[w]    = attr_hit && (vld_q[lk_idx] == lk_vld) && (vpn_q[lk_idx] == lk_vpn);
        assign way_ppn[w]  = ppn_q[lk_idx];
        assign way_attr[w] = attr_q[lk_idx];
    end
endmodule

// File: rtl/tlb_tp_resolve.sv
`timescale 1ns/1ps
module tlb_tp_resolve
    import tlb_tp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PPN_W = 20,
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(WAYS + 1)
) (
    input  logic [WAYS-1:0]              match,
    input  logic [WAYS-1:0][PPN_W-1:0]   way_ppn,
    input  logic [WAYS-1:0][ATTR_W-1:0]  way_attr,
    output logic                         hit,
    output logic                         multi,
    output logic [WAY_W-1:0]             hit_way,
    output logic [PPN_W-1:0]             hit_ppn,
    output logic [ATTR_W-1:0]            hit_attr
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt      = '0;
        hit_way  = '0;
        hit_ppn  = '0;
        hit_attr = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                cnt      = cnt + CNT_W'(1);
                hit_way  = hit_way | WAY_W'(w);
                hit_ppn  = hit_ppn | way_ppn[w];
                hit_attr = hit_attr | way_attr[w];
            end
        end
        hit   = (cnt == CNT_W'(1));
        multi = (cnt > CNT_W'(1));
        if (!hit) begin
            hit_way  = '0;
            hit_ppn  = '0;
            hit_attr = '0;
        end
    end
endmodule

// File: rtl/tlb_test_port.sv
`timescale 1ns/1ps
module tlb_test_port
    import tlb_tp_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        permit,
    input  logic        flush,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        dat_wr,
    input  logic [31:0] dat_wdata,
    input  logic        rd_en,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        busy,
    output logic        fault,
    output logic        multi_err
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int VPN_W = REG_W - PG_LSB;
    localparam int PPN_W = REG_W - PG_LSB;

    logic [REG_W-1:0] cmd_q, dat_q, pend_q;
    logic             fault_q, multi_q;
    logic             denied, accept_cmd, accept_dat;
    logic             do_write, do_lookup;

    logic [WAYS-1:0]             match;
    logic [WAYS-1:0][PPN_W-1:0]  way_ppn;
    logic [WAYS-1:0][ATTR_W-1:0] way_attr;
    logic                        lk_hit, lk_multi;
    logic [WAY_W-1:0]            hit_way;
    logic [PPN_W-1:0]            hit_ppn;
    logic [ATTR_W-1:0]           hit_attr;
    logic [REG_W-1:0]            look_cmd, look_dat;

    assign denied     = (cmd_wr | dat_wr | rd_en) & ~permit;
    assign accept_cmd = cmd_wr & permit & ~busy;
    assign accept_dat = dat_wr & permit & ~busy;

    tlb_tp_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept_cmd),
        .start_lookup (cmd_wdata[OP_BIT]),
        .busy         (busy),
        .do_write     (do_write),
        .do_lookup    (do_lookup)
    );

    tlb_tp_array #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .we       (do_write & dat_q[HIT_BIT]),
        .we_way   (dat_q[WAY_LSB +: WAY_W]),
        .we_idx   (pend_q[PG_LSB +: IDX_W]),
        .we_vpn   (pend_q[PG_LSB +: VPN_W]),
        .we_vld   (pend_q[VLD_BIT]),
        .we_attr  ({pend_q[DT_T], pend_q[US_T], pend_q[RW_T]}),
        .we_ppn   (dat_q[PG_LSB +: PPN_W]),
        .lk_idx   (pend_q[PG_LSB +: IDX_W]),
        .lk_vpn   (pend_q[PG_LSB +: VPN_W]),
        .lk_vld   (pend_q[VLD_BIT]),
        .lk_t     ({pend_q[DT_T], pend_q[US_T], pend_q[RW_T]}),
        .lk_c     ({pend_q[DT_C], pend_q[US_C], pend_q[RW_C]}),
        .match    (match),
        .way_ppn  (way_ppn),
        .way_attr (way_attr)
    );

    tlb_tp_resolve #(
        .WAYS  (WAYS),
        .PPN_W (PPN_W)
    ) u_resolve (
        .match    (match),
        .way_ppn  (way_ppn),
        .way_attr (way_attr),
        .hit      (lk_hit),
        .multi    (lk_multi),
        .hit_way  (hit_way),
        .hit_ppn  (hit_ppn),
        .hit_attr (hit_attr)
    );

    // lookup readback images
    always_comb begin
        look_cmd       = pend_q;
        look_cmd[DT_T] = hit_attr[A_D];
        look_cmd[DT_C] = ~hit_attr[A_D];
        look_cmd[US_T] = hit_attr[A_U];
        look_cmd[US_C] = ~hit_attr[A_U];
        look_cmd[RW_T] = hit_attr[A_W];
        look_cmd[RW_C] = ~hit_attr[A_W];
        look_dat                         = '0;
        look_dat[PG_LSB +: PPN_W]        = hit_ppn;
        look_dat[HIT_BIT]                = 1'b1;
        look_dat[WAY_LSB +: WAY_W]       = hit_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            dat_q   <= '0;
            pend_q  <= '0;
            fault_q <= 1'b0;
            multi_q <= 1'b0;
        end else begin
            fault_q <= denied;
            multi_q <= do_lookup & lk_multi;
            if (accept_cmd) pend_q <= cmd_wdata;
            if (accept_dat) dat_q  <= dat_wdata;
            if (do_write)   cmd_q  <= pend_q;
            if (do_lookup) begin
                if (lk_hit) begin
                    cmd_q <= look_cmd;
                    dat_q <= look_dat;
                end else begin
                    cmd_q <= pend_q;
                    dat_q <= '0;
                end
            end
        end
    end

    assign rd_data   = (rd_en && permit) ? (rd_sel ? dat_q : cmd_q) : '0;
    assign fault     = fault_q;
    assign multi_err = multi_q;
endmodule

// File: rtl/tlb_tp_chk.sv
`timescale 1ns/1ps
module tlb_tp_chk
    import tlb_tp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        permit,
    input logic        cmd_wr,
    input logic        dat_wr,
    input logic        rd_en,
    input logic        busy,
    input logic        fault,
    input logic        multi_err,
    input logic [31:0] dat_q
);
    // R10
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr && permit));

    // R11
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_wr || dat_wr || rd_en) && !permit) |=> fault);

    // R11
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past((cmd_wr || dat_wr || rd_en) && !permit));

    // R11
    denied_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_wr || dat_wr) && !permit && !busy) |=> (!busy && $stable(dat_q)));

    // R8
    multi_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |-> (dat_q == 32'd0));
endmodule

bind tlb_test_port tlb_tp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .permit    (permit),
    .cmd_wr    (cmd_wr),
    .dat_wr    (dat_wr),
    .rd_en     (rd_en),
    .busy      (busy),
    .fault     (fault),
    .multi_err (multi_err),
    .dat_q     (dat_q)
);

// File: tb/tlb_test_port_bench.sv
`timescale 1ns/1ps
module tlb_test_port_bench;
    logic        clk = 1'b0;
    logic        rst_n, permit, flush, cmd_wr, dat_wr, rd_en, rd_sel;
    logic [31:0] cmd_wdata, dat_wdata, rd_data;
    logic        busy, fault, multi_err;

    always #2 clk = ~clk;

    tlb_test_port u_tlb_test_port (
        .clk(clk), .rst_n(rst_n), .permit(permit), .flush(flush),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .fault(fault), .multi_err(multi_err)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model of the array and registers
    logic        m_v  [4][8];
    logic [19:0] m_pg [4][8];
    logic [2:0]  m_at [4][8];
    logic [19:0] m_pp [4][8];
    logic [31:0] m_cmd, m_dat;

    function automatic logic [31:0] mk_cmd(input logic [19:0] pg, input logic v,
        input logic [1:0] d, input logic [1:0] u, input logic [1:0] w, input logic op);
        return {pg, 4'b0, v, d, u, w, op};
    endfunction

    function automatic logic [31:0] mk_dat(input logic [19:0] pp, input logic h, input logic [1:0] way);
        return {pp, 7'b0, h, way, 2'b0};
    endfunction

    function automatic logic pok(input logic s, input logic t, input logic c);
        return s ? t : c;
    endfunction

    function automatic void predict(input logic [31:0] c, output logic [31:0] ecmd,
                                    output logic [31:0] edat, output logic emul);
        int n = 0;
        int hw = 0;
        int idx = int'(c[14:12]);
        for (int w = 0; w < 4; w++) begin
            if (m_pg[w][idx] == c[31:12] && m_v[w][idx] == c[7] &&
                pok(m_at[w][idx][2], c[6], c[5]) && pok(m_at[w][idx][1], c[4], c[3]) &&
                pok(m_at[w][idx][0], c[2], c[1])) begin
                n++;
                hw = w;
            end
        end
        ecmd = c;
        edat = 32'd0;
        emul = (n > 1);
        if (n == 1) begin
            ecmd[6] = m_at[hw][idx][2]; ecmd[5] = ~m_at[hw][idx][2];
            ecmd[4] = m_at[hw][idx][1]; ecmd[3] = ~m_at[hw][idx][1];
            ecmd[2] = m_at[hw][idx][0]; ecmd[1] = ~m_at[hw][idx][0];
            edat = mk_dat(m_pp[hw][idx], 1'b1, 2'(hw));
        end
    endfunction

    task automatic apply_write(input logic [31:0] c);
        int idx = int'(c[14:12]);
        int w   = int'(m_dat[3:2]);
        if (m_dat[4]) begin
            m_v[w][idx]  = c[7];
            m_pg[w][idx] = c[31:12];
            m_at[w][idx] = {c[6], c[4], c[2]};
            m_pp[w][idx] = m_dat[31:12];
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_en = 1'b1; rd_sel = sel;
        #0.5;
        v = rd_data;
        rd_en = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic wr_dat(input logic [31:0] d);
        dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_wr = 1'b0;
        m_dat = d;
    endtask

    task automatic run_cmd(input logic [31:0] c, input string req);
        logic [31:0] ecmd, edat, v;
        logic        emul;
        if (c[0]) predict(c, ecmd, edat, emul);
        else begin
            ecmd = c; edat = m_dat; emul = 1'b0;
            apply_write(c);
        end
        cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk({req, " R10 busy"}, 32'(busy), 32'd1);
        rd(1'b0, v); chk({req, " R10 old cmd while busy"}, v, m_cmd);
        @(negedge clk);
        chk({req, " R10 busy drop"}, 32'(busy), 32'd0);
        chk({req, " R8 multi_err"}, 32'(multi_err), 32'(emul));
        rd(1'b0, v); chk({req, " cmd readback"}, v, ecmd);
        rd(1'b1, v); chk({req, " dat readback"}, v, edat);
        m_cmd = ecmd; m_dat = edat;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 8; s++) m_v[w][s] = 1'b0;
    endtask

    function automatic logic [1:0] rnd_pair(input bit allow_any);
        int r = int'($urandom % 4);
        if (r == 0) return 2'b01;
        if (r == 1 || !allow_any) return r[0] ? 2'b10 : 2'b01;
        if (r == 2) return 2'b11;
        return 2'b10;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; permit = 1'b1; flush = 1'b0; cmd_wr = 1'b0; dat_wr = 1'b0;
        rd_en = 1'b0; rd_sel = 1'b0; cmd_wdata = '0; dat_wdata = '0;
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 8; s++) begin
                m_v[w][s] = 0; m_pg[w][s] = '0; m_at[w][s] = '0; m_pp[w][s] = '0;
            end
        m_cmd = '0; m_dat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 cmd after reset", v, 32'd0);
        rd(1'b1, v); chk("R1 dat after reset", v, 32'd0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 fault", 32'(fault), 0);
        chk("R1 multi_err", 32'(multi_err), 0);
        run_cmd(mk_cmd(20'h00003, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R1 empty lookup");

        // R2 R4 write then lookup
        wr_dat(mk_dat(20'hABCDE, 1'b1, 2'd2));
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b10, 2'b01, 2'b10, 1'b0), "R2 write");
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R4 hit");
        rd(1'b1, v); chk("R4 hit data image", v, mk_dat(20'hABCDE, 1'b1, 2'd2));
        // R5 pair semantics
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b01, 2'b11, 2'b11, 1'b1), "R5 dirty 01 vs stored 1");
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b11, 2'b00, 2'b11, 1'b1), "R5 pair 00");
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b10, 2'b01, 2'b10, 1'b1), "R5 exact pairs");
        // R6 valid as address bit
        run_cmd(mk_cmd(20'h12345, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1), "R6 valid 0 misses");
        // R7 miss on different page
        run_cmd(mk_cmd(20'h12355, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R7 miss");
        rd(1'b1, v); chk("R7 miss data zero", v, 32'd0);
        // R3 write with hit flag 0
        wr_dat(mk_dat(20'h55555, 1'b0, 2'd1));
        run_cmd(mk_cmd(20'h00F01, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0), "R3 write ignored");
        run_cmd(mk_cmd(20'h00F01, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R3 lookup after ignored write");
        // R8 duplicate tag
        wr_dat(mk_dat(20'h11111, 1'b1, 2'd0));
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0), "R8 dup write");
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R8 dup lookup");
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b01, 2'b11, 2'b11, 1'b1), "R8 dup split by pair");
        // R9 flush keeps tags, clears valid
        do_flush();
        run_cmd(mk_cmd(20'h12345, 1'b1, 2'b10, 2'b11, 2'b11, 1'b1), "R9 valid lookup after flush");
        run_cmd(mk_cmd(20'h12345, 1'b0, 2'b10, 2'b11, 2'b11, 1'b1), "R9 tag retained after flush");

        // R11 refused access
        permit = 1'b0;
        cmd_wr = 1'b1; cmd_wdata = mk_cmd(20'h00777, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0);
        dat_wr = 1'b1; dat_wdata = mk_dat(20'h77777, 1'b1, 2'd3);
        rd_en = 1'b1; rd_sel = 1'b1;
        #0.5;
        chk("R11 read refused", rd_data, 32'd0);
        @(negedge clk);
        cmd_wr = 1'b0; dat_wr = 1'b0; rd_en = 1'b0; rd_sel = 1'b0;
        chk("R11 fault pulse", 32'(fault), 1);
        chk("R11 no busy", 32'(busy), 0);
        permit = 1'b1;
        @(negedge clk);
        chk("R11 fault single cycle", 32'(fault), 0);
        rd(1'b0, v); chk("R11 cmd unchanged", v, m_cmd);
        rd(1'b1, v); chk("R11 dat unchanged", v, m_dat);

        // R10 writes during busy ignored
        wr_dat(mk_dat(20'h2468A, 1'b1, 2'd1));
        begin
            logic [31:0] c, ecmd, edat;
            logic emul;
            c = mk_cmd(20'h00042, 1'b1, 2'b01, 2'b10, 2'b01, 1'b0);
            apply_write(c);
            cmd_wr = 1'b1; cmd_wdata = c;
            @(negedge clk);
            cmd_wr = 1'b1; cmd_wdata = mk_cmd(20'h00042, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1);
            dat_wr = 1'b1; dat_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            cmd_wr = 1'b0; dat_wr = 1'b0;
            chk("R10 busy write not started", 32'(busy), 0);
            rd(1'b1, v); chk("R10 dat write during busy ignored", v, m_dat);
            rd(1'b0, v); chk("R10 cmd from accepted write", v, c);
            m_cmd = c;
            predict(mk_cmd(20'h00042, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), ecmd, edat, emul);
            run_cmd(mk_cmd(20'h00042, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1), "R10 R2 check entry");
        end

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int r = int'($urandom % 10);
            logic [19:0] pg = 20'($urandom % 48);
            if (r < 3) begin
                wr_dat(mk_dat(20'($urandom), ($urandom % 8) != 0, 2'($urandom % 4)));
                run_cmd(mk_cmd(pg, ($urandom % 6) != 0, rnd_pair(0), rnd_pair(0), rnd_pair(0), 1'b0),
                        "R2 R3 random write");
            end else if (r == 3 && (i % 50) == 49) begin
                do_flush();
            end else begin
                run_cmd(mk_cmd(pg, ($urandom % 6) != 0, rnd_pair(1), rnd_pair(1), rnd_pair(1), 1'b1),
                        "R4 R5 R6 R7 random lookup");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule